// File: doc/BRIEF.md
# Pixel Scan Sample Capture Controller

This block acquires one full frame from a 32 by 32 pixel sensor through a single pipelined analogue-to-digital converter. A one-cycle start pulse on the system clock launches a row-major walk over all 1024 pixels. For each pixel the block presents a 5-bit row address and a 5-bit column address, then gives the converter one rising edge of a sampling clock that it derives from the system clock. The converter returns each 14-bit word a fixed number of sampling cycles later, together with its own output clock. The block tags every sampling edge with the pixel index and carries that tag through a delay line clocked by the returning output clock. Each word is therefore written into a 1024 by 14 frame buffer at the index of the pixel that produced it.

When the last pixel's word has been stored, a toggle crosses back into the system-clock domain and the block raises a one-cycle frame-ready pulse. A separate read port with its own clock and enable then serves the stored frame. A start pulse that arrives while an acquisition is still in flight is dropped. The converter data and read interfaces are plain synchronous ports with no flow control. The converter cannot be stalled, and the read port always answers in the cycle after an enabled edge. For that reason there is no back-pressure at either edge.

Top module: `pixel_capture_ctrl`

## Requirements
- R1: After reset, frame_ready is low, row_o and col_o are 0, and a reset applied during a scan abandons that frame: no frame_ready follows it.
- R2: smp_clk_o toggles on every system-clock edge outside reset, so its period is two system-clock cycles, and row_o/col_o change only on the edges that bring smp_clk_o low.
- R3: Pixels are visited in row-major order, one per smp_clk_o period: col_o counts 0 to 31, and row_o advances when col_o wraps. After index 1023 the address returns to 0.
- R4: From an accepted start until its frame_ready, further start pulses are ignored: frame_ready arrives between 2040 and 2110 system-clock cycles after the accepted start.
- R5: The word captured on the rising edge of adc_dclk that comes 14 cycles after a sampling edge is stored at the linear index {row, col} of that edge, with row in index bits 9:5 and col in bits 4:0. For example, row 01111 with col 10101 is index 501.
- R6: frame_ready is high for exactly one system-clock cycle, once per frame, and only after all 1024 words have been written.
- R7: When rd_en is high at a rising rd_clk edge, rd_data shows the word at rd_addr just after that edge; when rd_en is low, rd_data holds.
- R8: While no frame is in flight, row_o and col_o stay at 0 and frame_ready stays low.
- R9: A later frame overwrites every word of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, system-clock domain |
| start | input | 1 | One-cycle pulse that launches a frame acquisition |
| frame_ready | output | 1 | One-cycle pulse: the whole frame is in the buffer |
| rd_clk | input | 1 | Read-port clock |
| rd_en | input | 1 | Read enable, sampled on rd_clk rising edge |
| rd_addr | input | 10 | Read index {row, col} |
| rd_data | output | 14 | Read word |
| smp_clk_o | output | 1 | Sampling clock to the converter (rising edge samples) |
| adc_dclk | input | 1 | Converter output clock, aligned with adc_data |
| adc_data | input | 14 | Converter output word |
| row_o | output | 5 | Pixel row address |
| col_o | output | 5 | Pixel column address |

## Verification
A tag that slips by one stage in the delay line shows at the read port as every stored word being the neighbour pixel's value. The bench gives each pixel a unique value, so the first table read after frame_ready exposes this. A scan counter that skips or repeats shows within one smp_clk_o period as a non-incrementing address step. A broken hand-off of the completion toggle shows as a missing, doubled or late frame_ready, about 30 system cycles after the last pixel is sampled. A restart leaking through the busy guard delays frame_ready by hundreds of cycles, and the bench catches that in its arrival window.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int ROW_BITS_DEF = 5;
  localparam int COL_BITS_DEF = 5;
  localparam int WORD_BITS_DEF = 14;
  localparam int PIPE_DEPTH_DEF = 14;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ARM   = 2'd1,
    SC_SCAN  = 2'd2,
    SC_DRAIN = 2'd3
  } scan_state_t;
endpackage

// File: rtl/pcc_scan.sv
module pcc_scan #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done_pulse,
  output logic             smp_clk,
  output logic [IDX_W-1:0] pix_idx,
  output logic             tag_vld,
  output logic             tag_last,
  output logic             busy
);
  import pcc_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  scan_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_clk <= 1'b0;
      state   <= SC_IDLE;
      pix_idx <= '0;
    end else begin
      smp_clk <= ~smp_clk;
      case (state)
        SC_IDLE:  if (start) state <= SC_ARM;
        SC_ARM:   if (smp_clk) state <= SC_SCAN;
        SC_SCAN: begin
          if (smp_clk) begin
            pix_idx <= pix_idx + 1'b1;
            if (pix_idx == LAST_IDX) state <= SC_DRAIN;
          end
        end
        SC_DRAIN: if (done_pulse) state <= SC_IDLE;
        default:  state <= SC_IDLE;
      endcase
    end
  end

  assign tag_vld  = (state == SC_SCAN);
  assign tag_last = tag_vld && (pix_idx == LAST_IDX);
  assign busy     = (state != SC_IDLE);
endmodule

// File: rtl/pcc_align.sv
module pcc_align #(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 14,
  parameter int DEPTH  = 14
) (
  input  logic              dclk,
  input  logic              rst,
  input  logic              tag_vld,
  input  logic              tag_last,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [WORD_W-1:0] adc_word,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_word,
  output logic              done_tgl
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] last_q;
  logic [IDX_W-1:0] idx_q [DEPTH];

  always_ff @(posedge dclk or posedge rst) begin
    if (rst) begin
      vld_q    <= '0;
      last_q   <= '0;
      done_tgl <= 1'b0;
    end else begin
      vld_q  <= {vld_q[DEPTH-2:0], tag_vld};
      last_q <= {last_q[DEPTH-2:0], tag_last};
      if (vld_q[DEPTH-1] && last_q[DEPTH-1]) done_tgl <= ~done_tgl;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge dclk) idx_q[s] <= tag_idx;
    end else begin : g_body
      always_ff @(posedge dclk) idx_q[s] <= idx_q[s-1];
    end
  end

  assign wr_en   = vld_q[DEPTH-1];
  assign wr_addr = idx_q[DEPTH-1];
  assign wr_word = adc_word;
endmodule

// File: rtl/pcc_pulse_sync.sv
module pcc_pulse_sync (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 ^ s3;
endmodule

// File: rtl/pcc_frame_ram.sv
module pcc_frame_ram #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 14
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [ENTRIES];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/pixel_capture_ctrl.sv
module pixel_capture_ctrl #(
  parameter int ROW_W   = pcc_pkg::ROW_BITS_DEF,
  parameter int COL_W   = pcc_pkg::COL_BITS_DEF,
  parameter int DATA_W  = pcc_pkg::WORD_BITS_DEF,
  parameter int LATENCY = pcc_pkg::PIPE_DEPTH_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     frame_ready,
  input  logic                     rd_clk,
  input  logic                     rd_en,
  input  logic [ROW_W+COL_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     smp_clk_o,
  input  logic                     adc_dclk,
  input  logic [DATA_W-1:0]        adc_data,
  output logic [ROW_W-1:0]         row_o,
  output logic [COL_W-1:0]         col_o
);
  localparam int IDX_W = ROW_W + COL_W;

  logic [IDX_W-1:0]  pix_idx;
  logic              tag_vld, tag_last, scan_busy;
  logic              wr_en, done_tgl;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_word;

  pcc_scan #(.IDX_W(IDX_W)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done_pulse (frame_ready),
    .smp_clk    (smp_clk_o),
    .pix_idx    (pix_idx),
    .tag_vld    (tag_vld),
    .tag_last   (tag_last),
    .busy       (scan_busy)
  );

  pcc_align #(.IDX_W(IDX_W), .WORD_W(DATA_W), .DEPTH(LATENCY)) u_align (
    .dclk     (adc_dclk),
    .rst      (rst),
    .tag_vld  (tag_vld),
    .tag_last (tag_last),
    .tag_idx  (pix_idx),
    .adc_word (adc_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  (wr_word),
    .done_tgl (done_tgl)
  );

  pcc_pulse_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .tgl_in (done_tgl),
    .pulse  (frame_ready)
  );

  pcc_frame_ram #(.ADDR_W(IDX_W), .WORD_W(DATA_W)) u_ram (
    .wr_clk  (adc_dclk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_word (wr_word),
    .rd_clk  (rd_clk),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_word (rd_data)
  );

  assign row_o = pix_idx[IDX_W-1:COL_W];
  assign col_o = pix_idx[COL_W-1:0];
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int ROW_W = 5,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             frame_ready,
  input logic             smp_clk_o,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o,
  input logic             scan_busy
);
  logic rst_q = 1'b1;
  always_ff @(posedge clk) rst_q <= rst;

  logic [ROW_W+COL_W-1:0] pix;
  assign pix = {row_o, col_o};

  // R6: ready pulse is a single cycle
  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    frame_ready |=> !frame_ready);

  // R8: no ready while nothing is in flight
  a_r8_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
    !scan_busy |-> !frame_ready);

  // R8: address parked at zero when idle
  a_r8_idle_addr: assert property (@(posedge clk) disable iff (rst)
    !scan_busy |-> (pix == '0));

  // R2: sampling clock toggles every system cycle
  a_r2_clk_toggles: assert property (@(posedge clk) disable iff (rst || rst_q)
    smp_clk_o != $past(smp_clk_o));

  // R2: address moves only as the sampling clock falls
  a_r2_addr_phase: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(pix) |-> !smp_clk_o);

  // R3: each address step is a plus-one increment with wrap
  a_r3_step: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(pix) |-> (pix == $past(pix) + 1'b1));

  // R4: a start during an acquisition leaves it running
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && scan_busy && !frame_ready) |=> scan_busy);
endmodule

bind pixel_capture_ctrl pcc_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .frame_ready (frame_ready),
  .smp_clk_o   (smp_clk_o),
  .row_o       (row_o),
  .col_o       (col_o),
  .scan_busy   (scan_busy)
);

// File: tb/tb_pixel_capture_ctrl.sv
`timescale 1ns/1ps
module tb_pixel_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        start = 1'b0;
  logic        frame_ready;
  logic        rd_clk = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic [13:0] rd_data;
  logic        smp_clk_o;
  logic        adc_dclk = 1'b0;
  logic [13:0] adc_data = '0;
  logic [4:0]  row_o, col_o;

  int checks = 0;
  int errors = 0;
  int seed = 0;
  int cyc = 0;

  pixel_capture_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .frame_ready(frame_ready),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .smp_clk_o(smp_clk_o), .adc_dclk(adc_dclk), .adc_data(adc_data),
    .row_o(row_o), .col_o(col_o)
  );

  always #10 clk = ~clk;
  always #7 rd_clk = ~rd_clk;

  function automatic logic [13:0] pix_val(input int idx, input int sd);
    int t;
    t = idx * 41 + sd * 977 + 3;
    return t[13:0];
  endfunction

  // Converter model: 14-cycle pipeline, output clock lags the sampling clock
  logic [13:0] pipe [14];
  always @(smp_clk_o) adc_dclk <= #2 smp_clk_o;
  always @(posedge smp_clk_o) begin
    pipe[0] <= pix_val(int'({row_o, col_o}), seed);
    for (int i = 1; i < 14; i++) pipe[i] <= pipe[i-1];
  end
  always @(negedge smp_clk_o) adc_data <= pipe[13];

  // Monitors, sampled mid-cycle
  int ready_cnt = 0, width_err = 0, phase_err = 0, toggle_err = 0;
  int order_err = 0, steps = 0;
  logic prev_ready = 1'b0, prev_smp = 1'b0, prev_rst = 1'b1;
  logic [9:0] prev_pix = '0, last_smp_pix = '0;

  always @(negedge clk) begin
    cyc++;
    if (frame_ready) ready_cnt++;
    if (frame_ready && prev_ready) width_err++;
    if (!rst && !prev_rst) begin
      if ({row_o, col_o} != prev_pix && smp_clk_o !== 1'b0) phase_err++;
      if (smp_clk_o == prev_smp) toggle_err++;
    end
    prev_ready = frame_ready;
    prev_smp = smp_clk_o;
    prev_rst = rst;
    prev_pix = {row_o, col_o};
  end

  always @(posedge smp_clk_o) begin
    if ({row_o, col_o} != last_smp_pix) begin
      steps++;
      if ({row_o, col_o} != last_smp_pix + 10'd1) order_err++;
    end
    last_smp_pix = {row_o, col_o};
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_ready(output int lat);
    int target;
    target = ready_cnt + 1;
    lat = 1;
    while (ready_cnt < target && lat < 5000) begin
      @(posedge clk);
      lat++;
    end
  endtask

  task automatic rd_word(input logic [9:0] a, output logic [13:0] v);
    @(negedge rd_clk);
    rd_en = 1'b1;
    rd_addr = a;
    @(posedge rd_clk);
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic frame_mismatches(input int sd, output int bad);
    logic [13:0] v;
    bad = 0;
    for (int i = 0; i < 1024; i++) begin
      rd_word(10'(i), v);
      if (v != pix_val(i, sd)) bad++;
    end
  endtask

  typedef struct packed { logic [4:0] row; logic [4:0] col; logic [9:0] idx; } probe_t;
  localparam probe_t PROBES [8] = '{
    '{row: 5'd15, col: 5'd21, idx: 10'd501},
    '{row: 5'd0,  col: 5'd0,  idx: 10'd0},
    '{row: 5'd0,  col: 5'd31, idx: 10'd31},
    '{row: 5'd1,  col: 5'd0,  idx: 10'd32},
    '{row: 5'd31, col: 5'd31, idx: 10'd1023},
    '{row: 5'd16, col: 5'd0,  idx: 10'd512},
    '{row: 5'd0,  col: 5'd7,  idx: 10'd7},
    '{row: 5'd30, col: 5'd30, idx: 10'd990}
  };

  initial begin : watchdog
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lat, bad, rc;
    logic [13:0] v, hold;

    // R1: reset state
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1;
    check(frame_ready == 1'b0, "R1 ready low after reset", int'(frame_ready), 0);
    check({row_o, col_o} == 10'd0, "R1 address zero after reset", int'({row_o, col_o}), 0);

    // R8: idle keeps still
    repeat (200) @(negedge clk);
    check(ready_cnt == 0, "R8 no ready while idle", ready_cnt, 0);
    check({row_o, col_o} == 10'd0, "R8 address parked while idle", int'({row_o, col_o}), 0);

    // Frame 1 with a second start mid-scan (R4)
    seed = 1;
    pulse_start();
    repeat (600) @(negedge clk);
    pulse_start();
    wait_ready(lat);
    lat = lat + 602;
    check(lat >= 2040 && lat <= 2110, "R4 ready arrival window", lat, 2080);
    repeat (100) @(negedge clk);
    check(ready_cnt == 1, "R6 one ready per frame", ready_cnt, 1);
    check(width_err == 0, "R6 ready width one cycle", width_err, 0);
    check(toggle_err == 0, "R2 sampling clock toggles", toggle_err, 0);
    check(phase_err == 0, "R2 address changes while sampling clock low", phase_err, 0);
    check(order_err == 0, "R3 row-major increment", order_err, 0);
    check(steps == 1024, "R3 one pixel per sampling period", steps, 1024);
    check({row_o, col_o} == 10'd0, "R8 address back to zero after frame", int'({row_o, col_o}), 0);

    // R5: probe table walk
    foreach (PROBES[k]) begin
      rd_word({PROBES[k].row, PROBES[k].col}, v);
      check(v == pix_val(int'(PROBES[k].idx), 1), "R5 probe word at pixel index",
            int'(v), int'(pix_val(int'(PROBES[k].idx), 1)));
    end
    frame_mismatches(1, bad);
    check(bad == 0, "R5 R6 whole frame stored at aligned indices", bad, 0);

    // R7: read enable low holds the output
    rd_word(10'd501, hold);
    @(negedge rd_clk);
    rd_addr = 10'd0;
    rd_en = 1'b0;
    @(posedge rd_clk);
    #1 check(rd_data == hold, "R7 output held with enable low", int'(rd_data), int'(hold));

    // R9: second frame overwrites
    seed = 2;
    pulse_start();
    wait_ready(lat);
    check(ready_cnt == 2, "R9 second frame ready", ready_cnt, 2);
    frame_mismatches(2, bad);
    check(bad == 0, "R9 second frame replaces first", bad, 0);
    check(order_err == 0, "R3 order over two frames", order_err, 0);

    // R1: reset in mid-scan abandons the frame
    seed = 3;
    pulse_start();
    repeat (500) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rc = ready_cnt;
    repeat (2400) @(negedge clk);
    check(ready_cnt == rc, "R1 no ready after mid-scan reset", ready_cnt, rc);
    check({row_o, col_o} == 10'd0, "R1 address zero after mid-scan reset", int'({row_o, col_o}), 0);

    // R1: recovery frame after the abandoned one
    seed = 4;
    pulse_start();
    wait_ready(lat);
    check(lat >= 2040 && lat <= 2110, "R1 R4 frame after reset in window", lat, 2080);
    frame_mismatches(4, bad);
    check(bad == 0, "R5 frame after reset stored correctly", bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule